// File: doc/BRIEF.md
# Per-Slot Global-History Direction Predictor with Fetch Context Queue

This block predicts taken or not-taken for every instruction slot of a wide fetch in one cycle. The fetch PC selects a table row after being XORed with a global history of recent branch outcomes. Each row holds one 2-bit saturating counter per slot, so a 64-bit fetch with four 16-bit slots gets four independent direction bits at once.

Every fetch that carries branches leaves a context record in a small queue. The record holds the row that was read, a tag, the number of branches still to resolve and a flag for an instruction that straddles the previous fetch. Resolved branches train the counter named by the oldest record, not the row the current history would select. Replayed fetches leave no record. An explicit flush, an overflow of this queue, or an overflow signalled by the downstream instruction or address queues empties it.

Top module: `slot_gshare_pred`

## Requirements
- R1: After reset every counter holds 01 (weakly not-taken), the history is zero and the queue is empty (`q_level` = 0). A slot predicts taken exactly when the upper bit of its counter is 1.
- R2: The lookup row is `lk_pc[10:3]` XOR the 8-bit history and is shown on `pred_row`; `pred_taken[i]` comes from column i of that row, for i = 0..3, in the same cycle.
- R3: On every cycle with `res_valid` the history shifts left by one, with `res_taken` entering bit 0, whether or not the tag matched.
- R4: A matching resolve increments the selected counter when taken and decrements it when not taken, saturating at 3 and at 0.
- R5: A push stores the lookup row of its own cycle, and later updates use that stored row, even after the history has moved.
- R6: `res_hit` is 1 only when `res_valid` is high, the queue is non-empty and `res_tag` equals the oldest record's tag. On a miss no counter changes and the record's pending count is kept.
- R7: The oldest record leaves the queue on the matching resolve that brings its pending count (initially `push_brcnt`) to zero.
- R8: When the oldest record's unaligned flag is set, the trained column is (`res_slot` + 1) mod 4; otherwise it is `res_slot`.
- R9: A push with `push_replay` high or with `push_brcnt` = 0 leaves the queue unchanged.
- R10: A push while the queue holds 4 records, with no pop in the same cycle, empties the queue and the push is dropped; with a pop in the same cycle the push is accepted.
- R11: `flush_req`, `iq_ovf` or `aq_ovf` empties the queue by the next cycle and drops any push of that cycle.
- R12: A lookup in the same cycle as an update of the same counter sees the counter's old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | Fetch PC for lookup and push |
| pred_taken | output | 4 | Direction bit per slot |
| pred_row | output | 8 | Row selected by the lookup |
| push_en | input | 1 | Record a context for this fetch |
| push_replay | input | 1 | Fetch will be replayed, suppress the push |
| push_tag | input | 4 | Tag stored with the record |
| push_brcnt | input | 3 | Number of branches in the fetch |
| push_unal | input | 1 | Fetch starts with a straddling instruction |
| res_valid | input | 1 | A branch has resolved |
| res_slot | input | 2 | Slot of the resolved branch |
| res_taken | input | 1 | Outcome of the resolved branch |
| res_tag | input | 4 | Tag carried by the resolved branch |
| res_hit | output | 1 | Resolve matched the oldest record |
| flush_req | input | 1 | Empty the queue |
| iq_ovf | input | 1 | Downstream instruction queue overflowed |
| aq_ovf | input | 1 | Downstream address queue overflowed |
| q_level | output | 3 | Records held in the queue |

## Verification
Every one of the 256 rows is swept right after reset to show all columns start not-taken and that the PC bits select the row. Directed runs drive one counter up past 3 and down past 0, resolve with a stale tag, train a straddling fetch, and look up a row in the very cycle it is written, separating saturation, tag filtering, column realignment and read-before-write. Queue runs fill to four with and without a same-cycle pop, replay and zero-branch pushes, and each flush source. A long mixed random sequence with small tags then compares every prediction, hit and occupancy with an arithmetic model of history, counters and queue.

// File: rtl/slot_gshare_pred.sv
module slot_gshare_pred #(
  parameter int SLOTS  = 4,
  parameter int HIST_W = 8,
  parameter int PC_W   = 32,
  parameter int TAG_W  = 4,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [PC_W-1:0]            lk_pc,
  output logic [SLOTS-1:0]           pred_taken,
  output logic [HIST_W-1:0]          pred_row,
  input  logic                       push_en,
  input  logic                       push_replay,
  input  logic [TAG_W-1:0]           push_tag,
  input  logic [CNT_W-1:0]           push_brcnt,
  input  logic                       push_unal,
  input  logic                       res_valid,
  input  logic [$clog2(SLOTS)-1:0]   res_slot,
  input  logic                       res_taken,
  input  logic [TAG_W-1:0]           res_tag,
  output logic                       res_hit,
  input  logic                       flush_req,
  input  logic                       iq_ovf,
  input  logic                       aq_ovf,
  output logic [$clog2(DEPTH+1)-1:0] q_level
);
  localparam int ROWS   = 1 << HIST_W;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int PC_LSB = SLOT_W + 1;
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int LVL_W  = $clog2(DEPTH + 1);

  logic [1:0]        ctr [ROWS][SLOTS];
  logic [HIST_W-1:0] ghr;

  logic [HIST_W-1:0] e_row  [DEPTH];
  logic [TAG_W-1:0]  e_tag  [DEPTH];
  logic [CNT_W-1:0]  e_cnt  [DEPTH];
  logic              e_unal [DEPTH];
  logic [PTR_W-1:0]  head, tail;
  logic [LVL_W-1:0]  level;

  logic              pop, push_ok, flush_any, overflow, clear, do_push;
  logic [SLOT_W-1:0] upd_col;
  logic [HIST_W-1:0] upd_row;

  assign pred_row = lk_pc[PC_LSB +: HIST_W] ^ ghr;
  assign q_level  = level;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign pred_taken[g] = ctr[pred_row][g][1];
  end

  assign res_hit   = res_valid && (level != '0) && (e_tag[head] == res_tag);
  assign upd_row   = e_row[head];
  assign upd_col   = res_slot + SLOT_W'(e_unal[head]);
  assign pop       = res_hit && (e_cnt[head] == CNT_W'(1));
  assign push_ok   = push_en && !push_replay && (push_brcnt != '0);
  assign flush_any = flush_req || iq_ovf || aq_ovf;
  assign overflow  = push_ok && (level == LVL_W'(DEPTH)) && !pop;
  assign clear     = flush_any || overflow;
  assign do_push   = push_ok && !clear;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        for (int s = 0; s < SLOTS; s++)
          ctr[r][s] <= 2'b01;
    end else if (res_hit) begin
      if (res_taken && ctr[upd_row][upd_col] != 2'b11)
        ctr[upd_row][upd_col] <= ctr[upd_row][upd_col] + 2'b01;
      else if (!res_taken && ctr[upd_row][upd_col] != 2'b00)
        ctr[upd_row][upd_col] <= ctr[upd_row][upd_col] - 2'b01;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         ghr <= '0;
    else if (res_valid) ghr <= {ghr[HIST_W-2:0], res_taken};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      level <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        e_row[i]  <= '0;
        e_tag[i]  <= '0;
        e_cnt[i]  <= '0;
        e_unal[i] <= 1'b0;
      end
    end else if (clear) begin
      head  <= '0;
      tail  <= '0;
      level <= '0;
    end else begin
      if (pop)          head <= head + PTR_W'(1);
      else if (res_hit) e_cnt[head] <= e_cnt[head] - CNT_W'(1);
      if (do_push) begin
        e_row[tail]  <= pred_row;
        e_tag[tail]  <= push_tag;
        e_cnt[tail]  <= push_brcnt;
        e_unal[tail] <= push_unal;
        tail         <= tail + PTR_W'(1);
      end
      level <= level + LVL_W'(do_push) - LVL_W'(pop);
    end
  end

  assert_level_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_any |=> level == '0);

  assert_overflow_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && !push_replay && push_brcnt != '0 && level == LVL_W'(DEPTH) && !res_hit)
      |=> level == '0);

  assert_replay_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && push_replay && !res_valid && !flush_any) |=> level == $past(level));

  assert_ghr_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> (ghr[0] == $past(res_taken)) && (ghr[HIST_W-1:1] == $past(ghr[HIST_W-2:0])));

  assert_miss_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit && !push_en && !flush_any) |=> level == $past(level));

  assert_hit_needs_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> level != '0);
endmodule

// File: tb/slot_gshare_pred_test.sv
module slot_gshare_pred_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] lk_pc = '0;
  logic [3:0] pred_taken;
  logic [7:0] pred_row;
  logic push_en = 0, push_replay = 0, push_unal = 0;
  logic [3:0] push_tag = '0;
  logic [2:0] push_brcnt = '0;
  logic res_valid = 0, res_taken = 0;
  logic [1:0] res_slot = '0;
  logic [3:0] res_tag = '0;
  logic res_hit;
  logic flush_req = 0, iq_ovf = 0, aq_ovf = 0;
  logic [2:0] q_level;

  always #5 clk = ~clk;

  slot_gshare_pred uut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .pred_taken(pred_taken), .pred_row(pred_row),
    .push_en(push_en), .push_replay(push_replay), .push_tag(push_tag), .push_brcnt(push_brcnt),
    .push_unal(push_unal), .res_valid(res_valid), .res_slot(res_slot), .res_taken(res_taken),
    .res_tag(res_tag), .res_hit(res_hit), .flush_req(flush_req), .iq_ovf(iq_ovf),
    .aq_ovf(aq_ovf), .q_level(q_level));

  int errors = 0, checks = 0;
  bit done = 0;

  int mctr [256][4];
  int mghr = 0;
  int mrow [4], mtag [4], mcnt [4], munal [4];
  int mh = 0, mt = 0, mlvl = 0;

  // staged stimulus
  logic [31:0] s_pc = '0;
  bit s_pe = 0, s_rep = 0, s_un = 0, s_rv = 0, s_rt = 0, s_fl = 0, s_iq = 0, s_aq = 0;
  int s_ptag = 0, s_bc = 0, s_rs = 0, s_rtag = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_stage();
    s_pe = 0; s_rep = 0; s_un = 0; s_rv = 0; s_rt = 0; s_fl = 0; s_iq = 0; s_aq = 0;
    s_ptag = 0; s_bc = 0; s_rs = 0; s_rtag = 0;
  endtask

  task automatic tick(string req);
    int erow, epred, ehit, epop, pok, clr, col;
    @(negedge clk);
    lk_pc = s_pc; push_en = s_pe; push_replay = s_rep; push_tag = 4'(s_ptag);
    push_brcnt = 3'(s_bc); push_unal = s_un; res_valid = s_rv; res_slot = 2'(s_rs);
    res_taken = s_rt; res_tag = 4'(s_rtag); flush_req = s_fl; iq_ovf = s_iq; aq_ovf = s_aq;
    #1;
    erow = ((s_pc >> 3) & 255) ^ mghr;
    epred = 0;
    for (int i = 0; i < 4; i++) if (mctr[erow][i] >= 2) epred |= (1 << i);
    ehit = (s_rv && mlvl > 0 && mtag[mh] == s_rtag) ? 1 : 0;
    check({req, " row"}, int'(pred_row), erow);
    check({req, " pred"}, int'(pred_taken), epred);
    check({req, " hit"}, int'(res_hit), ehit);
    epop = (ehit && mcnt[mh] == 1) ? 1 : 0;
    pok = (s_pe && !s_rep && s_bc != 0) ? 1 : 0;
    clr = (s_fl || s_iq || s_aq || (pok && mlvl == 4 && !epop)) ? 1 : 0;
    @(posedge clk);
    #1;
    if (ehit) begin
      col = munal[mh] ? (s_rs + 1) % 4 : s_rs;
      if (s_rt && mctr[mrow[mh]][col] < 3) mctr[mrow[mh]][col]++;
      if (!s_rt && mctr[mrow[mh]][col] > 0) mctr[mrow[mh]][col]--;
    end
    if (s_rv) mghr = ((mghr << 1) | int'(s_rt)) & 255;
    if (clr) begin
      mh = 0; mt = 0; mlvl = 0;
    end else begin
      if (epop) begin mh = (mh + 1) % 4; mlvl--; end
      else if (ehit) mcnt[mh]--;
      if (pok) begin
        mrow[mt] = erow; mtag[mt] = s_ptag; mcnt[mt] = s_bc; munal[mt] = s_un;
        mt = (mt + 1) % 4; mlvl++;
      end
    end
    check({req, " level"}, int'(q_level), mlvl);
    clear_stage();
  endtask

  // pc whose lookup lands on row r under the current model history
  function automatic logic [31:0] pc_for(int r);
    return 32'((r ^ mghr) << 3);
  endfunction

  task automatic push(int pc, int tag, int bc, bit un, string req);
    s_pc = 32'(pc); s_pe = 1; s_ptag = tag; s_bc = bc; s_un = un; tick(req);
  endtask

  task automatic resolve(int slot, bit tk, int tag, string req);
    s_rv = 1; s_rs = slot; s_rt = tk; s_rtag = tag; tick(req);
  endtask

  initial begin
    int r0;
    for (int r = 0; r < 256; r++) for (int s = 0; s < 4; s++) mctr[r][s] = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #2 check("R1 reset level", int'(q_level), 0);

    // R1 R2: sweep all rows right after reset
    for (int r = 0; r < 256; r++) begin s_pc = 32'(r << 3) | 32'(r & 7); tick("R1 R2 sweep"); end

    // R4 R5: up-saturation on one counter, history moves between push and updates
    r0 = 37;
    push(int'(pc_for(r0)), 1, 4, 0, "R5 push");
    for (int k = 0; k < 4; k++) resolve(2, 1, 1, "R4 R7 up");
    s_pc = pc_for(r0); tick("R4 sat high");
    check("R4 sat high direct", int'(pred_taken[2]), 1);
    check("R4 counter model", mctr[r0][2], 3);
    push(int'(pc_for(r0)), 2, 3, 0, "R5 push");
    resolve(2, 0, 2, "R4 down");
    s_pc = pc_for(r0); tick("R4 still taken");
    check("R4 still taken direct", int'(pred_taken[2]), 1);
    resolve(2, 0, 2, "R4 down");
    resolve(2, 0, 2, "R4 R7 down pop");
    push(int'(pc_for(r0)), 3, 2, 0, "R5 push");
    resolve(2, 0, 3, "R4 floor");
    resolve(2, 0, 3, "R4 floor");
    check("R4 sat low", mctr[r0][2], 0);
    s_pc = pc_for(r0); tick("R4 low");

    // R8: unaligned record trains the next column
    r0 = 200;
    push(int'(pc_for(r0)), 5, 2, 1, "R8 push");
    resolve(3, 1, 5, "R8 wrap");
    resolve(3, 1, 5, "R8 wrap");
    s_pc = pc_for(r0); tick("R8 lookup");
    check("R8 column0 taken", int'(pred_taken), 4'b0001);
    push(int'(pc_for(r0)), 6, 2, 1, "R8 push");
    resolve(1, 1, 6, "R8 shift");
    resolve(1, 1, 6, "R8 shift");
    s_pc = pc_for(r0); tick("R8 lookup");
    check("R8 column2 taken", int'(pred_taken), 4'b0101);

    // R6: stale tag
    push(40, 7, 1, 0, "R6 push");
    resolve(0, 1, 8, "R6 miss");
    check("R6 miss keeps", int'(q_level), 1);
    resolve(0, 1, 7, "R6 R7 hit pop");
    check("R7 popped", int'(q_level), 0);
    resolve(0, 1, 7, "R6 empty miss");

    // R12: lookup of a counter in its update cycle
    r0 = 90;
    push(int'(pc_for(r0)), 9, 2, 0, "R12 push");
    s_pc = pc_for(r0); s_rv = 1; s_rs = 1; s_rt = 1; s_rtag = 9; tick("R12 same cycle old");
    s_pc = pc_for(r0); s_rv = 1; s_rs = 1; s_rt = 1; s_rtag = 9; tick("R12 same cycle old");
    s_pc = pc_for(r0); tick("R12 after");

    // R9: replay and zero-branch
    s_pe = 1; s_rep = 1; s_bc = 2; s_ptag = 1; tick("R9 replay");
    check("R9 replay", int'(q_level), 0);
    s_pe = 1; s_bc = 0; s_ptag = 1; tick("R9 zero count");
    check("R9 zero count", int'(q_level), 0);

    // R10: overflow, then full with same-cycle pop
    for (int k = 0; k < 4; k++) push(k * 8, k, 1, 0, "R10 fill");
    check("R10 full", int'(q_level), 4);
    push(64, 9, 1, 0, "R10 overflow");
    check("R10 overflow empties", int'(q_level), 0);
    for (int k = 0; k < 4; k++) push(k * 8, k, 1, 0, "R10 fill");
    s_pc = 72; s_pe = 1; s_ptag = 4; s_bc = 1; s_rv = 1; s_rs = 0; s_rt = 1; s_rtag = 0;
    tick("R10 pop and push");
    check("R10 pop and push", int'(q_level), 4);

    // R11: each flush source
    s_fl = 1; tick("R11 flush");
    check("R11 flush", int'(q_level), 0);
    push(8, 1, 2, 0, "R11 push");
    s_iq = 1; s_pe = 1; s_bc = 1; tick("R11 iq drops push");
    check("R11 iq", int'(q_level), 0);
    push(8, 1, 2, 0, "R11 push");
    s_aq = 1; tick("R11 aq");
    check("R11 aq", int'(q_level), 0);

    // R3 and mixed random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      int u = int'($urandom);
      s_pc = 32'($urandom) & 32'h7ff;
      s_pe = (u & 3) == 0; s_rep = (u & 112) == 0; s_bc = (u >> 8) % 5;
      s_un = (u >> 11) & 1; s_ptag = (u >> 12) & 3;
      s_rv = ((u >> 14) & 1) == 1; s_rs = (u >> 15) & 3; s_rt = (u >> 17) & 1;
      s_rtag = (u >> 18) & 3; s_fl = ((u >> 20) & 63) == 0;
      s_iq = ((u >> 26) & 63) == 1; s_aq = ((u >> 26) & 63) == 2;
      tick("R2 R3 R4 R6 R7 random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule